// File: doc/BRIEF.md
# Clock/Calendar Interrupt and Alarm Controller

This block gathers the timing events of a clock/calendar and turns them into interrupts for a host processor. It receives one-cycle rollover pulses from the counter chain (hundredths, tenths, seconds, minutes, hours, days), the present seconds, minutes, hours, day-of-month, month and day-of-week counter values, and an internal power-fail level. From these it keeps a set of sticky periodic flags, a status register with periodic, alarm and power-fail bits, and an alarm comparator with a separate enable for each compare byte.

The host reaches the registers through a byte-wide port with a 4-bit address and single-cycle read and write strobes. Reads return data combinationally. A bank bit in the status register picks what addresses 1 and 2 show. The active-low interrupt output is driven while any enabled event is pending. A multi-function output carries either the gated power-fail interrupt (active high) or a buffered copy of the oscillator clock.

Address map: 0 status (any bank); 1 periodic flags (bank 0) or periodic enables (bank 1); 2 reads 0 (bank 0) or alarm/power control (bank 1); 3 output mode; 4 to 9 compare bytes for seconds, minutes, hours, day of month, month, day of week; 10 to 15 read 0.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset all registers read 0, `irq_n` is 1 and `mfo` is 0.
- R2: A pulse on `tick[i]` sets bit i of the flag register (address 1, bank 0). Any read or write of that location clears all six flags. A tick in the same cycle as the access still leaves its flag set.
- R3: Status bit 2 (periodic) is set when `tick & en` is non-zero, where `en` is the enable register (address 1, bank 1, bits 5:0). Writing 1 to status bit 2 clears it. Reading the status, clearing the flags or zeroing the enables does not clear it. A set in the same cycle as a clear wins.
- R4: Control bits 0 to 5 (address 2, bank 1) enable comparison of seconds, minutes, hours, day of month, month and day of week against compare bytes at addresses 4 to 9. A disabled byte counts as equal. Compare bytes read back as written.
- R5: Status bit 3 (alarm) sets in the cycle after the comparison first becomes true, with at least one compare enable set. It is not set again while the match holds. It sets whether or not control bit 6 is set, and it is cleared by writing 1 to it. With no compare enable set it never sets.
- R6: Status bit 1 equals `pwr_fail` as sampled at the previous clock edge.
- R7: Status bit 0 reads 1 exactly when `irq_n` is driven low.
- R8: `irq_n` is 0 when status bit 2 is set, or bit 3 with control bit 6, or bit 1 with control bit 7, and is 1 otherwise.
- R9: Output-mode bit 7 (address 3) at 0 drives `mfo` with status bit 1 AND control bit 7. At 1 it drives `mfo` with `osc_clk`. The other output-mode bits read 0.
- R10: Status bit 6 is a read/write bank select that chooses what addresses 1 and 2 show. Writes to address 1 or 2 in bank 0 change no enable or control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational from addr) |
| tick | input | 6 | Rollover pulses, fastest counter in bit 0 |
| cnt_sec | input | 8 | Seconds counter value |
| cnt_min | input | 8 | Minutes counter value |
| cnt_hour | input | 8 | Hours counter value |
| cnt_dom | input | 8 | Day-of-month counter value |
| cnt_mon | input | 8 | Month counter value |
| cnt_dow | input | 8 | Day-of-week counter value |
| pwr_fail | input | 1 | Internal power-fail level, active high |
| osc_clk | input | 1 | Oscillator clock for the multi-function output |
| irq_n | output | 1 | Interrupt request, active low |
| mfo | output | 1 | Multi-function output |

## Verification
The embedded properties check these rules on every cycle:
- flag clearing on access;
- write-1 clearing of the periodic bit, and that a status read leaves it set;
- the one-cycle lag of the power-fail bit;
- that a new alarm needs a compare enable.

The scenarios are needed for the remaining behaviour:
- the single alarm per match episode, and re-arming after the match drops;
- a disabled compare byte counting as equal;
- a pending periodic bit that outlives its enables;
- set-over-clear collisions;
- bank selection;
- routing the oscillator onto the multi-function output.

A behavioural model in the bench predicts `irq_n`, `mfo` and the read data in every cycle.

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int ADDR_W   = 4,
  parameter int NUM_TICK = 6,
  parameter int NUM_CMP  = 6,
  parameter int CMP_BASE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [NUM_TICK-1:0] tick,
  input  logic [7:0]        cnt_sec,
  input  logic [7:0]        cnt_min,
  input  logic [7:0]        cnt_hour,
  input  logic [7:0]        cnt_dom,
  input  logic [7:0]        cnt_mon,
  input  logic [7:0]        cnt_dow,
  input  logic              pwr_fail,
  input  logic              osc_clk,
  output logic              irq_n,
  output logic              mfo
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(3);

  logic [NUM_TICK-1:0] flags, en_per;
  logic [7:0]          ctl1;
  logic [7:0]          cmp_q [NUM_CMP];
  logic [7:0]          cnt_v [NUM_CMP];
  logic                osc_sel, bank, st_pf, st_per, st_alm, match_q, match, irq_act;

  assign cnt_v[0] = cnt_sec;
  assign cnt_v[1] = cnt_min;
  assign cnt_v[2] = cnt_hour;
  assign cnt_v[3] = cnt_dom;
  assign cnt_v[4] = cnt_mon;
  assign cnt_v[5] = cnt_dow;

  always_comb begin
    match = |ctl1[NUM_CMP-1:0];
    for (int i = 0; i < NUM_CMP; i++)
      if (ctl1[i] && cmp_q[i] != cnt_v[i]) match = 1'b0;
  end

  wire wr_stat  = wr_en && addr == A_STAT;
  wire flag_hit = (rd_en || wr_en) && addr == A_FLAG && !bank;

  assign irq_act = st_per | (st_alm & ctl1[6]) | (st_pf & ctl1[7]);
  assign irq_n   = ~irq_act;
  assign mfo     = osc_sel ? osc_clk : (st_pf & ctl1[7]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags   <= '0;
      en_per  <= '0;
      ctl1    <= '0;
      osc_sel <= 1'b0;
      bank    <= 1'b0;
      st_pf   <= 1'b0;
      st_per  <= 1'b0;
      st_alm  <= 1'b0;
      match_q <= 1'b0;
      for (int i = 0; i < NUM_CMP; i++) cmp_q[i] <= '0;
    end else begin
      st_pf   <= pwr_fail;
      match_q <= match;
      flags   <= (flag_hit ? '0 : flags) | tick;
      st_per  <= (st_per & ~(wr_stat & wdata[2])) | (|(tick & en_per));
      st_alm  <= (st_alm & ~(wr_stat & wdata[3])) | (match & ~match_q);
      if (wr_en) begin
        if (addr == A_STAT) bank <= wdata[6];
        if (addr == A_FLAG && bank) en_per <= wdata[NUM_TICK-1:0];
        if (addr == A_CTL && bank) ctl1 <= wdata;
        if (addr == A_MODE) osc_sel <= wdata[7];
        for (int i = 0; i < NUM_CMP; i++)
          if (addr == ADDR_W'(CMP_BASE + i)) cmp_q[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_STAT: rdata = {1'b0, bank, 2'b00, st_alm, st_per, st_pf, irq_act};
      A_FLAG: rdata = 8'(bank ? en_per : flags);
      A_CTL:  rdata = bank ? ctl1 : 8'h00;
      A_MODE: rdata = {osc_sel, 7'b0};
      default: begin
        for (int i = 0; i < NUM_CMP; i++)
          if (addr == ADDR_W'(CMP_BASE + i)) rdata = cmp_q[i];
      end
    endcase
  end

  assert_flag_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && addr == A_FLAG && !bank && tick == '0) |=> flags == '0);

  assert_w1c_per_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT && wdata[2] && (tick & en_per) == '0) |=> !st_per);

  assert_read_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == A_STAT && st_per) |=> st_per);

  assert_alarm_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_alm) |-> $past(|ctl1[NUM_CMP-1:0]));

  assert_pf_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> st_pf);

  assert_pf_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_fail |=> !st_pf);
endmodule

// File: tb/rtc_irq_ctrl_tb_top.sv
module rtc_irq_ctrl_tb_top;
  logic clk = 0, rst_n = 0, rd_en = 0, wr_en = 0, pwr_fail = 0, osc_clk = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [5:0] tick = 0;
  logic [7:0] cnt [6];
  logic irq_n, mfo;
  int checks = 0, fails = 0, cyc = 0;

  int m_flags, m_per, m_alm, m_pf, m_bank, m_c0, m_c1, m_mode, m_prev;
  int m_cmp [6];

  always #2 clk = ~clk;

  rtc_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick(tick),
    .cnt_sec(cnt[0]), .cnt_min(cnt[1]), .cnt_hour(cnt[2]),
    .cnt_dom(cnt[3]), .cnt_mon(cnt[4]), .cnt_dow(cnt[5]),
    .pwr_fail(pwr_fail), .osc_clk(osc_clk), .irq_n(irq_n), .mfo(mfo));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int m_irq();
    return (m_per != 0 || (m_alm != 0 && m_c1[6]) || (m_pf != 0 && m_c1[7])) ? 1 : 0;
  endfunction

  function automatic int m_read(int a);
    if (a == 0) return (m_bank << 6) | (m_alm << 3) | (m_per << 2) | (m_pf << 1) | m_irq();
    if (a == 1) return m_bank != 0 ? m_c0 : m_flags;
    if (a == 2) return m_bank != 0 ? m_c1 : 0;
    if (a == 3) return m_mode;
    if (a >= 4 && a <= 9) return m_cmp[a-4];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flags = 0; m_per = 0; m_alm = 0; m_pf = 0; m_bank = 0;
      m_c0 = 0; m_c1 = 0; m_mode = 0; m_prev = 0;
      for (int i = 0; i < 6; i++) m_cmp[i] = 0;
    end else begin
      int hit, any;
      any = (m_c1 & 63) != 0;
      hit = any;
      for (int i = 0; i < 6; i++)
        if (m_c1[i] && m_cmp[i] != int'(cnt[i])) hit = 0;
      if ((rd_en || wr_en) && addr == 1 && m_bank == 0) m_flags = 0;
      m_flags = m_flags | int'(tick);
      if (wr_en && addr == 0 && wdata[2]) m_per = 0;
      if ((int'(tick) & m_c0) != 0) m_per = 1;
      if (wr_en && addr == 0 && wdata[3]) m_alm = 0;
      if (hit != 0 && m_prev == 0) m_alm = 1;
      m_prev = hit;
      m_pf = int'(pwr_fail);
      if (wr_en) begin
        if (addr == 0) m_bank = int'(wdata[6]);
        else if (addr == 1 && m_bank != 0) m_c0 = int'(wdata) & 63;
        else if (addr == 2 && m_bank != 0) m_c1 = int'(wdata);
        else if (addr == 3) m_mode = int'(wdata) & 128;
        else if (addr >= 4 && addr <= 9) m_cmp[addr-4] = int'(wdata);
      end
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk("R8 irq_n", int'(irq_n), 1 - m_irq());
      chk("R9 mfo", int'(mfo), m_mode != 0 ? int'(osc_clk) : ((m_pf != 0 && m_c1[7]) ? 1 : 0));
      if (rd_en) begin
        string t;
        t = addr == 0 ? "R3 status" : addr == 1 ? "R2 flags" : addr == 2 ? "R10 ctl" :
            addr == 3 ? "R9 mode" : "R4 compare";
        chk(t, int'(rdata), m_read(int'(addr)));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic op(input logic r, input logic w, input int a, input int d,
                    input int tk, output logic [7:0] q);
    @(negedge clk);
    rd_en = r; wr_en = w; addr = 4'(a); wdata = 8'(d); tick = 6'(tk);
    #1 q = rdata;
  endtask

  task automatic idle(input int n);
    logic [7:0] q;
    for (int i = 0; i < n; i++) op(0, 0, 0, 0, 0, q);
  endtask

  task automatic wr(input int a, input int d);
    logic [7:0] q;
    op(0, 1, a, d, 0, q);
  endtask

  task automatic rd(input int a, output logic [7:0] q);
    op(1, 0, a, 0, 0, q);
  endtask

  task automatic pulse(input int tk);
    logic [7:0] q;
    op(0, 0, 0, 0, tk, q);
  endtask

  initial begin
    logic [7:0] q;
    cnt[0] = 8'h29; cnt[1] = 8'h15; cnt[2] = 8'h07;
    cnt[3] = 8'h11; cnt[4] = 8'h07; cnt[5] = 8'h02;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(1);
    rd(0, q); chk("R1 status", q, 8'h00);
    rd(1, q); chk("R1 flags", q, 8'h00);
    chk("R1 irq_n", irq_n, 1); chk("R1 mfo", mfo, 0);

    pulse(6'b000101);
    rd(1, q); chk("R2 flags set", q, 8'h05);
    rd(1, q); chk("R2 flags cleared by read", q, 8'h00);
    rd(0, q); chk("R3 no enable no status", q & 8'h04, 0);
    op(1, 0, 1, 0, 6'b100000, q);
    rd(1, q); chk("R2 tick wins over clear", q, 8'h20);
    wr(1, 8'hFF);
    rd(1, q); chk("R2 write clears flags", q, 8'h00);

    wr(0, 8'h40); wr(1, 8'h02); wr(2, 8'h00);
    pulse(6'b000001);
    rd(0, q); chk("R3 masked tick", q, 8'h40);
    pulse(6'b000010);
    rd(0, q); chk("R3 R7 R10 periodic pending", q, 8'h45);
    chk("R8 irq low", irq_n, 0);
    rd(1, q); chk("R10 bank1 enables", q, 8'h02);
    wr(0, 8'h00);
    rd(1, q); chk("R2 flags in bank0", q, 8'h03);
    rd(0, q); chk("R3 flag clear keeps status", q, 8'h05);
    wr(0, 8'h40); wr(1, 8'h00);
    rd(0, q); chk("R3 pending without enables", q, 8'h45);
    wr(0, 8'h44);
    rd(0, q); chk("R3 w1c", q, 8'h40);
    chk("R7 irq high", irq_n, 1);

    wr(1, 8'h3F);
    op(0, 1, 0, 8'h44, 6'b000100, q);
    rd(0, q); chk("R3 set wins over clear", q, 8'h45);
    wr(0, 8'h44); wr(1, 8'h00);
    wr(0, 8'h00); wr(2, 8'hC3); wr(0, 8'h40);
    rd(2, q); chk("R10 bank0 write ignored", q, 8'h00);

    wr(4, 8'h30); wr(5, 8'h15); wr(6, 8'h03); wr(7, 8'h11); wr(8, 8'h07); wr(9, 8'h02);
    rd(6, q); chk("R4 compare readback", q, 8'h03);
    wr(2, 8'h03);
    idle(1);
    rd(0, q); chk("R5 no match", q, 8'h40);
    @(negedge clk) cnt[0] = 8'h30;
    idle(1);
    rd(0, q); chk("R5 R4 alarm masked pin", q, 8'h48);
    chk("R5 irq masked", irq_n, 1);
    wr(2, 8'h43);
    rd(0, q); chk("R5 R8 alarm on pin", q, 8'h49);
    wr(0, 8'h48); idle(2);
    rd(0, q); chk("R5 single set per match", q, 8'h40);
    @(negedge clk) cnt[0] = 8'h31;
    @(negedge clk) cnt[0] = 8'h30;
    idle(1);
    rd(0, q); chk("R5 re-armed", q, 8'h49);
    wr(0, 8'h48); wr(2, 8'h40);
    @(negedge clk) cnt[0] = 8'h31;
    @(negedge clk) cnt[0] = 8'h30;
    idle(2);
    rd(0, q); chk("R5 no enables no alarm", q, 8'h40);
    wr(2, 8'h44); idle(1);
    @(negedge clk) cnt[2] = 8'h03;
    idle(1);
    rd(0, q); chk("R4 hour compare alone", q, 8'h49);
    wr(0, 8'h48); wr(2, 8'h00);

    @(negedge clk) pwr_fail = 1;
    idle(1);
    rd(0, q); chk("R6 pf status masked", q, 8'h42);
    chk("R9 mfo masked", mfo, 0);
    wr(2, 8'h80);
    rd(0, q); chk("R6 R7 pf on pin", q, 8'h43);
    chk("R9 mfo pf", mfo, 1);
    wr(3, 8'hFF);
    rd(3, q); chk("R9 mode readback", q, 8'h80);
    @(negedge clk) osc_clk = 1;
    #1 chk("R9 mfo osc high", mfo, 1);
    @(negedge clk) osc_clk = 0;
    #1 chk("R9 mfo osc low", mfo, 0);
    @(negedge clk) pwr_fail = 0;
    idle(2);
    rd(0, q); chk("R6 restored", q, 8'h40);
    chk("R8 irq released", irq_n, 1);
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule